// File: doc/BRIEF.md
# Exception Stack Frame Builder

When an exception is accepted, this block writes a two-longword frame onto the supervisor stack. It then requests the handler address from the vector table. The request carries the vector number, a 4-bit fault status, a flag marking the exception as fault-class, the current 16-bit status register, two program counters (the faulting one and the next one), the supervisor stack pointer and the vector table base. The frame goes out through a 32-bit write port with a valid/ready handshake. The vector read goes out through a separate request port with its own handshake.

The stack pointer may be misaligned when the exception arrives. The block forces it back to a longword boundary, and it records the two discarded low bits in the format nibble of the frame. The second frame longword packs these fields together:

- the format nibble;
- the fault status, split into two halves that sit on either side of the 8-bit vector field;
- the status register.

When the vector read is accepted, the block does three things. It pulses a done flag, it presents the new stack pointer, and it raises an inhibit flag that blocks interrupt sampling. The inhibit flag stays high until the core reports that the first handler instruction has retired. While a frame is in progress, a busy output tells the requester that a new exception is not being taken.

Top module: `exc_frame_builder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy, mem_wr_valid, vec_rd_valid, done and int_inhibit are 0 and sp_out is 0.
- R2: A request seen with req_valid=1 while the block is idle is accepted at that edge. From the next cycle, the first write is presented at address A+4, where A = (req_sp with bits 1:0 cleared) − 8.
- R3: The first write carries req_pc_fault when req_fault_class=1 and req_pc_next when req_fault_class=0.
- R4: After the first write's handshake, the second write goes to address A. Its data has bits 31:28 = 4 + req_sp[1:0], bits 27:26 = FS[3:2], bits 25:18 = vector, bits 17:16 = FS[1:0] and bits 15:0 = req_sr.
- R5: When req_fault_class=0, the FS bits of the second write (27:26 and 17:16) are zero, whatever req_fs holds.
- R6: A write stays valid, with unchanged address and data, until it is seen with mem_wr_ready=1. The block advances only on that handshake.
- R7: In the cycle after the second write's handshake, vec_rd_valid rises with vec_rd_addr = req_vbase + 4·vector. It holds, unchanged, until vec_rd_ready=1. It is never high together with mem_wr_valid.
- R8: In the cycle after the vector read handshake, done is high for exactly one cycle and sp_out equals A. sp_out keeps that value until the next frame completes.
- R9: busy is high from the cycle after acceptance through the cycle of the vector read handshake. A request presented while busy has no effect on any frame.
- R10: int_inhibit rises together with done. It stays high until first_insn_retired is sampled high, and it is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Exception request strobe |
| req_vector | input | 8 | Exception vector number |
| req_fault_class | input | 1 | 1 = access/address error: keep FS, stack faulting PC |
| req_fs | input | 4 | Fault status |
| req_sr | input | 16 | Status register at the exception |
| req_pc_fault | input | 32 | PC of the faulting instruction |
| req_pc_next | input | 32 | PC of the following instruction |
| req_sp | input | 32 | Supervisor stack pointer at the exception |
| req_vbase | input | 32 | Vector table base address |
| busy | output | 1 | Frame in progress, requests not taken |
| mem_wr_valid | output | 1 | Stack write valid |
| mem_wr_addr | output | 32 | Stack write address |
| mem_wr_data | output | 32 | Stack write data |
| mem_wr_ready | input | 1 | Stack write accepted |
| vec_rd_valid | output | 1 | Vector table read request |
| vec_rd_addr | output | 32 | Vector table entry address |
| vec_rd_ready | input | 1 | Vector read accepted |
| done | output | 1 | One-cycle frame completion pulse |
| sp_out | output | 32 | Stack pointer for the handler |
| int_inhibit | output | 1 | Interrupt sampling blocked |
| first_insn_retired | input | 1 | First handler instruction retired |

## Verification
A wrong sequencer state shows up within one cycle as a valid on the wrong port, a missing handshake, or busy disagreeing with the frame phase. Because the model is compared on every clock, the first stray cycle is caught. A corrupted latched word shows as a wrong address or data on the very write that uses it. A bad alignment or format computation appears as soon as a stack pointer with nonzero low bits is used, and every low-bit value is exercised. An inhibit flag that drops early or sticks is visible in the cycle after first_insn_retired, or in the cycle after done.

// File: rtl/exc_frame_pkg.sv
// Package: shared widths, frame field positions and the sequencer state type.
// Assumes a 32-bit address space with longword (4-byte) stack slots.
package exc_frame_pkg;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned SR_W    = 16;
    localparam int unsigned VEC_W   = 8;
    localparam int unsigned FS_W    = 4;
    localparam int unsigned FMT_W   = 4;
    localparam int unsigned ALIGN_B = 2;                 // longword alignment bits
    localparam int unsigned FRAME_B = 8;                 // bytes in one frame
    localparam logic [FMT_W-ALIGN_B-1:0] FMT_BASE = 2'b01; // format = 4 + low bits

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WR_PC = 2'd1,
        ST_WR_FV = 2'd2,
        ST_FETCH = 2'd3
    } frame_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] new_sp;
        logic [ADDR_W-1:0] pc_word;
        logic [ADDR_W-1:0] fv_word;
        logic [ADDR_W-1:0] fetch_addr;
    } frame_plan_t;
endpackage

// File: rtl/exc_frame_compose.sv
// Module: exc_frame_compose
// Turns a raw exception request into the finished frame plan: the aligned new
// stack pointer, both frame longwords and the vector table entry address.
// Purely combinational; the sequencer latches the result at acceptance.
module exc_frame_compose
    import exc_frame_pkg::*;
(
    input  logic [VEC_W-1:0]  vector,
    input  logic              fault_class,
    input  logic [FS_W-1:0]   fs,
    input  logic [SR_W-1:0]   sr,
    input  logic [ADDR_W-1:0] pc_fault,
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] vbase,
    output frame_plan_t       plan
);
    localparam int unsigned HALF_FS = FS_W / 2;

    logic [ADDR_W-1:0] sp_aligned;
    logic [FS_W-1:0]   fs_kept;
    logic [FMT_W-1:0]  fmt;

    // Purpose: clear the misalignment, keep FS only for fault-class exceptions.
    always_comb begin
        sp_aligned = {sp[ADDR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
        fs_kept    = fault_class ? fs : '0;
        fmt        = {FMT_BASE, sp[ALIGN_B-1:0]};
    end

    // Purpose: assemble the frame plan fields.
    always_comb begin
        plan.new_sp     = sp_aligned - ADDR_W'(FRAME_B);
        plan.pc_word    = fault_class ? pc_fault : pc_next;
        plan.fv_word    = {fmt, fs_kept[FS_W-1:HALF_FS], vector,
                           fs_kept[HALF_FS-1:0], sr};
        plan.fetch_addr = vbase + {{(ADDR_W-VEC_W-ALIGN_B){1'b0}}, vector,
                                   {ALIGN_B{1'b0}}};
    end
endmodule

// File: rtl/exc_frame_seq.sv
// Module: exc_frame_seq
// Sequences one frame: PC write, format/status write, vector read, each held
// until its ready. Latches the composed plan at acceptance; requests while
// busy are not taken. Emits a registered done pulse with the new SP.
module exc_frame_seq
    import exc_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  frame_plan_t       plan_in,
    output logic              busy,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [ADDR_W-1:0] mem_wr_data,
    input  logic              mem_wr_ready,
    output logic              vec_rd_valid,
    output logic [ADDR_W-1:0] vec_rd_addr,
    input  logic              vec_rd_ready,
    output logic              fetch_done,
    output logic              done,
    output logic [ADDR_W-1:0] sp_out
);
    frame_state_e state_q, state_d;
    frame_plan_t  plan_q;
    logic         accept;
    logic         done_q;
    logic [ADDR_W-1:0] sp_q;

    // Purpose: decode acceptance and the fetch handshake.
    always_comb begin
        accept     = (state_q == ST_IDLE) && req_valid;
        fetch_done = (state_q == ST_FETCH) && vec_rd_ready;
    end

    // Purpose: next-state selection, advancing only on handshakes.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)    state_d = ST_WR_PC;
            ST_WR_PC: if (mem_wr_ready) state_d = ST_WR_FV;
            ST_WR_FV: if (mem_wr_ready) state_d = ST_FETCH;
            ST_FETCH: if (vec_rd_ready) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register and frame plan latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            plan_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) plan_q <= plan_in;
        end
    end

    // Purpose: completion pulse and the published stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            sp_q   <= '0;
        end else begin
            done_q <= fetch_done;
            if (fetch_done) sp_q <= plan_q.new_sp;
        end
    end

    // Purpose: drive the port outputs from the current phase.
    always_comb begin
        busy         = (state_q != ST_IDLE);
        mem_wr_valid = (state_q == ST_WR_PC) || (state_q == ST_WR_FV);
        mem_wr_addr  = (state_q == ST_WR_PC) ? plan_q.new_sp + ADDR_W'(4)
                                             : plan_q.new_sp;
        mem_wr_data  = (state_q == ST_WR_PC) ? plan_q.pc_word : plan_q.fv_word;
        vec_rd_valid = (state_q == ST_FETCH);
        vec_rd_addr  = plan_q.fetch_addr;
        done         = done_q;
        sp_out       = sp_q;
    end

    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=>
            mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));
    p_wr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> mem_wr_addr[ALIGN_B-1:0] == '0);
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd_valid && !vec_rd_ready |=> vec_rd_valid && $stable(vec_rd_addr));
    p_port_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_valid && vec_rd_valid));
    p_done_after_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(vec_rd_valid && vec_rd_ready));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_sp_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sp_out[ALIGN_B-1:0] == '0);
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |=> busy);
endmodule

// File: rtl/exc_frame_inhibit.sv
// Module: exc_frame_inhibit
// Holds the interrupt-sampling inhibit from frame completion until the core
// reports the first handler instruction retired. Set wins over clear.
module exc_frame_inhibit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic retired_i,
    output logic inhibit_o
);
    logic inh_q;

    // Purpose: set/clear flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)         inh_q <= 1'b0;
        else if (set_i)     inh_q <= 1'b1;
        else if (retired_i) inh_q <= 1'b0;
    end

    assign inhibit_o = inh_q;

    p_inh_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_o && !retired_i |=> inhibit_o);
    p_inh_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_o && retired_i && !set_i |=> !inhibit_o);
    p_inh_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> inhibit_o);
endmodule

// File: rtl/exc_frame_builder.sv
// Module: exc_frame_builder (top)
// Builds the two-longword exception frame on the supervisor stack, fetches
// the vector entry, publishes the new SP and blocks interrupt sampling until
// the handler's first instruction retires. Assumes memory and vector ports
// follow valid/ready: a transfer happens at an edge where both are high.
module exc_frame_builder
    import exc_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic              req_fault_class,
    input  logic [FS_W-1:0]   req_fs,
    input  logic [SR_W-1:0]   req_sr,
    input  logic [ADDR_W-1:0] req_pc_fault,
    input  logic [ADDR_W-1:0] req_pc_next,
    input  logic [ADDR_W-1:0] req_sp,
    input  logic [ADDR_W-1:0] req_vbase,
    output logic              busy,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [ADDR_W-1:0] mem_wr_data,
    input  logic              mem_wr_ready,
    output logic              vec_rd_valid,
    output logic [ADDR_W-1:0] vec_rd_addr,
    input  logic              vec_rd_ready,
    output logic              done,
    output logic [ADDR_W-1:0] sp_out,
    output logic              int_inhibit,
    input  logic              first_insn_retired
);
    frame_plan_t plan;
    logic        fetch_done;

    exc_frame_compose u_compose (
        .vector      (req_vector),
        .fault_class (req_fault_class),
        .fs          (req_fs),
        .sr          (req_sr),
        .pc_fault    (req_pc_fault),
        .pc_next     (req_pc_next),
        .sp          (req_sp),
        .vbase       (req_vbase),
        .plan        (plan)
    );

    exc_frame_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .plan_in      (plan),
        .busy         (busy),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_ready (mem_wr_ready),
        .vec_rd_valid (vec_rd_valid),
        .vec_rd_addr  (vec_rd_addr),
        .vec_rd_ready (vec_rd_ready),
        .fetch_done   (fetch_done),
        .done         (done),
        .sp_out       (sp_out)
    );

    exc_frame_inhibit u_inhibit (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (fetch_done),
        .retired_i (first_insn_retired),
        .inhibit_o (int_inhibit)
    );

    p_inh_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> int_inhibit);
endmodule

// File: tb/exc_frame_builder_test.sv
`timescale 1ns/1ps
module exc_frame_builder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic        req_fault_class = 1'b0;
    logic [3:0]  req_fs = '0;
    logic [15:0] req_sr = '0;
    logic [31:0] req_pc_fault = '0, req_pc_next = '0, req_sp = '0, req_vbase = '0;
    logic        busy, mem_wr_valid, vec_rd_valid, done, int_inhibit;
    logic [31:0] mem_wr_addr, mem_wr_data, vec_rd_addr, sp_out;
    logic        mem_wr_ready = 1'b0, vec_rd_ready = 1'b0, first_insn_retired = 1'b0;

    always #2.5 clk = ~clk;

    exc_frame_builder uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_fault_class(req_fault_class), .req_fs(req_fs), .req_sr(req_sr),
        .req_pc_fault(req_pc_fault), .req_pc_next(req_pc_next), .req_sp(req_sp),
        .req_vbase(req_vbase), .busy(busy), .mem_wr_valid(mem_wr_valid),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ready(mem_wr_ready), .vec_rd_valid(vec_rd_valid),
        .vec_rd_addr(vec_rd_addr), .vec_rd_ready(vec_rd_ready), .done(done),
        .sp_out(sp_out), .int_inhibit(int_inhibit),
        .first_insn_retired(first_insn_retired)
    );

    int n_chk = 0, n_bad = 0;
    bit checking = 1'b0;
    bit finished = 1'b0;
    int stall_mode = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model: phase number, queue of expected writes, expected flags.
    int          ph = 0;
    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    string       q_tag[$];
    logic [31:0] e_fetch = 0, e_newsp = 0, e_sp = 0;
    bit          e_done = 0, e_inh = 0, m_stalled = 0, m_fin;
    logic [31:0] t_sp, t_fv;
    logic [3:0]  t_fs;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; q_addr.delete(); q_data.delete(); q_tag.delete();
            e_done = 0; e_inh = 0; e_sp = 0; m_stalled = 0;
        end else begin
            m_fin = (ph == 3) && vec_rd_ready;
            e_done = m_fin;
            if (m_fin) e_sp = e_newsp;
            if (m_fin) e_inh = 1;
            else if (first_insn_retired) e_inh = 0;
            m_stalled = ((ph == 1 || ph == 2) && !mem_wr_ready) ||
                        (ph == 3 && !vec_rd_ready);
            case (ph)
                0: if (req_valid) begin
                    t_sp = req_sp - (req_sp % 4) - 8;
                    e_newsp = t_sp;
                    t_fs = req_fault_class ? req_fs : 4'd0;
                    t_fv = ((32'd4 + (req_sp % 4)) << 28) | (32'(t_fs >> 2) << 26) |
                           (32'(req_vector) << 18) | (32'(t_fs % 4) << 16) |
                           32'(req_sr);
                    q_addr.push_back(t_sp + 4);
                    q_data.push_back(req_fault_class ? req_pc_fault : req_pc_next);
                    q_tag.push_back("R3");
                    q_addr.push_back(t_sp);
                    q_data.push_back(t_fv);
                    q_tag.push_back((!req_fault_class && req_fs != 0) ? "R5" : "R4");
                    e_fetch = req_vbase + 32'(req_vector) * 4;
                    ph = 1;
                end
                1, 2: if (mem_wr_ready) begin
                    void'(q_addr.pop_front()); void'(q_data.pop_front());
                    void'(q_tag.pop_front());
                    ph = ph + 1;
                end
                default: if (vec_rd_ready) ph = 0;
            endcase
        end
    end

    // Compare every output against the model away from the clock edge.
    always @(negedge clk) begin
        if (checking && rst_n) begin
            chk(busy == (ph != 0), "R9", "busy", 32'(busy), 32'(ph != 0));
            chk(mem_wr_valid == (ph == 1 || ph == 2), m_stalled ? "R6" : "R2",
                "mem_wr_valid", 32'(mem_wr_valid), 32'(ph == 1 || ph == 2));
            if (mem_wr_valid && q_addr.size() > 0) begin
                chk(mem_wr_addr == q_addr[0],
                    m_stalled ? "R6" : ((ph == 1) ? "R2" : "R4"),
                    "mem_wr_addr", mem_wr_addr, q_addr[0]);
                chk(mem_wr_data == q_data[0], m_stalled ? "R6" : q_tag[0],
                    "mem_wr_data", mem_wr_data, q_data[0]);
            end
            chk(vec_rd_valid == (ph == 3), "R7", "vec_rd_valid",
                32'(vec_rd_valid), 32'(ph == 3));
            if (vec_rd_valid)
                chk(vec_rd_addr == e_fetch, "R7", "vec_rd_addr", vec_rd_addr, e_fetch);
            chk(done == e_done, "R8", "done", 32'(done), 32'(e_done));
            chk(sp_out == e_sp, "R8", "sp_out", sp_out, e_sp);
            chk(int_inhibit == e_inh, "R10", "int_inhibit",
                32'(int_inhibit), 32'(e_inh));
        end
    end

    // Ready and retire drivers.
    initial begin
        forever begin
            @(negedge clk);
            if (stall_mode == 0) begin
                mem_wr_ready = 1'b1; vec_rd_ready = 1'b1;
            end else begin
                mem_wr_ready = ($urandom % 3) != 0;
                vec_rd_ready = ($urandom % 3) == 0;
            end
            first_insn_retired = ($urandom % 5) == 0;
        end
    end

    task automatic issue(input int i);
        logic [7:0] vecs [0:7];
        vecs = '{8'd2, 8'd3, 8'd32, 8'd47, 8'd64, 8'd255, 8'd24, 8'd100};
        while (busy) @(negedge clk);
        req_valid       = 1'b1;
        req_vector      = vecs[i % 8];
        req_fault_class = (i % 3) == 0;
        req_fs          = 4'(i) ^ 4'ha;
        req_sr          = 16'h2700 ^ 16'(i * 37);
        req_pc_fault    = 32'h0001_0000 + 32'(i * 6);
        req_pc_next     = 32'h0001_0002 + 32'(i * 6);
        req_sp          = 32'h0080_0000 - 32'(i * 13);
        req_vbase       = (i % 2) ? 32'h0000_0000 : 32'h0040_0000;
        @(negedge clk);
        if (i % 4 == 1) begin
            req_vector = 8'hEE; req_sp = 32'hDEAD_BEEF; req_sr = 16'hFFFF;
            req_pc_next = 32'h1234_5678; req_pc_fault = 32'h8765_4321;
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(busy == 0, "R1", "busy in reset", 32'(busy), 0);
        chk(mem_wr_valid == 0, "R1", "mem_wr_valid in reset", 32'(mem_wr_valid), 0);
        chk(vec_rd_valid == 0, "R1", "vec_rd_valid in reset", 32'(vec_rd_valid), 0);
        chk(done == 0, "R1", "done in reset", 32'(done), 0);
        chk(int_inhibit == 0, "R1", "int_inhibit in reset", 32'(int_inhibit), 0);
        chk(sp_out == 0, "R1", "sp_out in reset", sp_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && int_inhibit == 0, "R1", "after reset",
            {busy, done, int_inhibit}, 0);
        checking = 1'b1;
        for (int i = 0; i < 12; i++) issue(i);
        stall_mode = 1;
        for (int i = 12; i < 60; i++) issue(i);
        repeat (10) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule